// File: doc/BRIEF.md
# Multi-Operand Modulo Adder Tree

This block adds N operands, each a plain binary value below the modulus M, and delivers their total modulo M as a redundant pair of two W-bit vectors. The sum of the two vectors is congruent to the total modulo M. It is the accumulation stage of a residue-to-binary converter. The products of the residues and their weights come in on the operand lanes. A separate final reducer turns the pair into one binary result. Neither of those parts is in this block.

Each operand enters with a zero carry vector. A balanced binary tree of two-operand redundant modulo adders then merges neighbouring pairs, level by level, until one pair remains. There are ceil(log2 N) levels.

Each node works in two phases:
- It compresses its four input vectors with carry-save steps.
- Each carry that overflows bit W-1 has weight 2^W. The node removes that weight by adding the constant 2^W mod M through further carry-save steps, until no overflow remains.

No carry ever ripples across the word. The node delay therefore depends only on a fixed number of full-adder layers and not on W.

Every level ends in a register bank. When N is odd at some level, the unpaired lane goes through a plain register to the next level. A valid bit travels beside the data. The operand width W is ceil(log2 M).

Top module: `mod_sum_tree`

## Requirements
- R1: Whenever `out_vld` is high, (`out_s` + `out_c`) mod M equals the sum of the N operand lanes presented with the matching `in_vld`, taken mod M. Operand k occupies bits [k*W +: W] of `in_data`.
- R2: `out_vld` rises exactly D = ceil(log2 N) clock cycles after the cycle in which `in_vld` is high, and the pair it flags belongs to that cycle's operands.
- R3: A new operand set is accepted on every cycle with `in_vld` high. A cycle with `in_vld` low produces a cycle with `out_vld` low D cycles later and has no effect on the neighbouring results.
- R4: When every operand equals M-1, which is the largest value in every lane, the output pair is congruent to N*(M-1) mod M.
- R5: While `rst_n` is low, `out_vld` is low. After release it stays low until the first accepted operand set reaches the output.
- R6: When N is odd, the operand in the unpaired last lane reaches the result through the delay registers with its full weight. A set in which only that lane is non-zero yields a pair congruent to that value.
- R7: When M is a power of two, so that 2^W mod M is 0, overflow carries are simply dropped. The result stays congruent to the sum mod M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operand set valid |
| in_data | input | N*W | N operand lanes, each below M, lane k at [k*W +: W] |
| out_vld | output | 1 | Result pair valid |
| out_s | output | W | Sum vector of the result pair |
| out_c | output | W | Carry vector of the result pair |

## Verification
The bench runs two configurations: five lanes with modulus 11, and seven lanes with modulus 8. With all zeros and with all lanes at M-1, the tree shows whether the overflow folding keeps full weight at its heaviest load. Single non-zero lanes, and the last lane alone, expose a miswired pair or a lost pass-through operand. An exhaustive sweep of the first two lanes, with random fill elsewhere, separates a wrong fold constant from a wrong carry shift. Random sets with periodic invalid cycles confirm the latency and that bubbles keep their place in the stream.

// File: rtl/mtree_pkg.sv
package mtree_pkg;

    // Number of carry-save fold passes a node may need to clear overflow.
    // With 2^(W-1) < M <= 2^W and a node input total below 4*2^W, each
    // pass removes at least M, so seven passes always suffice.
    localparam int FOLDS = 7;

    // Operand count at a tree level: halve (rounding up) l times.
    function automatic int level_count(input int n, input int l);
        int c;
        c = n;
        for (int i = 0; i < l; i++) begin
            c = (c + 1) / 2;
        end
        return c;
    endfunction

    // Residue of the overflow weight 2^w modulo mod.
    function automatic int fold_const(input int mod, input int w);
        longint unsigned big;
        big = longint'(1) << w;
        return int'(big % longint'(mod));
    endfunction

endpackage

// File: rtl/mod_add_node.sv
module mod_add_node #(
    parameter int W   = 4,
    parameter int MOD = 11
) (
    input  logic [W-1:0] a_s,
    input  logic [W-1:0] a_c,
    input  logic [W-1:0] b_s,
    input  logic [W-1:0] b_c,
    output logic [W-1:0] y_s,
    output logic [W-1:0] y_c,
    output logic         spill
);
    import mtree_pkg::*;

    localparam logic [W-1:0] KC    = W'(fold_const(MOD, W));
    localparam int           STEPS = FOLDS + 2;

    logic [W-1:0] s, c, x, sm, cy;
    logic [1:0]   pend;
    logic         use_step;

    // Steps 0 and 1 absorb the second operand pair.
    // Later steps trade one pending 2^W for the constant KC.
    always_comb begin
        s    = a_s;
        c    = a_c;
        pend = 2'd0;
        x    = '0;
        sm   = '0;
        cy   = '0;
        for (int k = 0; k < STEPS; k++) begin
            use_step = 1'b1;
            if (k == 0) begin
                x = b_s;
            end else if (k == 1) begin
                x = b_c;
            end else begin
                use_step = (pend != 2'd0);
                x        = KC;
            end
            if (use_step) begin
                if (k >= 2) begin
                    pend = pend - 2'd1;
                end
                sm   = s ^ c ^ x;
                cy   = (s & c) | (s & x) | (c & x);
                s    = sm;
                c    = {cy[W-2:0], 1'b0};
                pend = pend + {1'b0, cy[W-1]};
            end
        end
        y_s   = s;
        y_c   = c;
        spill = (pend != 2'd0);
    end

endmodule

// File: rtl/mod_tree_level.sv
module mod_tree_level #(
    parameter int NIN = 5,
    parameter int W   = 4,
    parameter int MOD = 11,
    localparam int NOUT  = (NIN + 1) / 2,
    localparam int NPAIR = NIN / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [NIN*W-1:0]  in_s,
    input  logic [NIN*W-1:0]  in_c,
    output logic              out_vld,
    output logic [NOUT*W-1:0] out_s,
    output logic [NOUT*W-1:0] out_c,
    output logic              spill
);

    logic [NOUT*W-1:0] nx_s, nx_c;
    logic [NPAIR-1:0]  node_spill;

    for (genvar p = 0; p < NPAIR; p++) begin : g_node
        mod_add_node #(.W(W), .MOD(MOD)) u_node (
            .a_s  (in_s[(2*p)*W +: W]),
            .a_c  (in_c[(2*p)*W +: W]),
            .b_s  (in_s[(2*p+1)*W +: W]),
            .b_c  (in_c[(2*p+1)*W +: W]),
            .y_s  (nx_s[p*W +: W]),
            .y_c  (nx_c[p*W +: W]),
            .spill(node_spill[p])
        );
    end

    if (NIN % 2 == 1) begin : g_pass
        assign nx_s[NPAIR*W +: W] = in_s[(NIN-1)*W +: W];
        assign nx_c[NPAIR*W +: W] = in_c[(NIN-1)*W +: W];
    end

    assign spill = in_vld & (|node_spill);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_s   <= '0;
            out_c   <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_s <= nx_s;
                out_c <= nx_c;
            end
        end
    end

endmodule

// File: rtl/mod_sum_tree.sv
module mod_sum_tree #(
    parameter int N   = 5,
    parameter int MOD = 11,
    localparam int W  = $clog2(MOD)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_vld,
    input  logic [N*W-1:0] in_data,
    output logic           out_vld,
    output logic [W-1:0]   out_s,
    output logic [W-1:0]   out_c
);
    import mtree_pkg::*;

    localparam int D = $clog2(N);

    logic [D-1:0] lvl_spill;
    logic         spill_any;

    for (genvar l = 0; l < D; l++) begin : g_lvl
        localparam int CIN  = level_count(N, l);
        localparam int COUT = level_count(N, l + 1);

        logic [CIN*W-1:0]  is_v, ic_v;
        logic              iv;
        logic [COUT*W-1:0] os, oc;
        logic              ov;

        if (l == 0) begin : g_first
            assign is_v = in_data;
            assign ic_v = '0;
            assign iv   = in_vld;
        end else begin : g_next
            assign is_v = g_lvl[l-1].os;
            assign ic_v = g_lvl[l-1].oc;
            assign iv   = g_lvl[l-1].ov;
        end

        mod_tree_level #(.NIN(CIN), .W(W), .MOD(MOD)) u_lvl (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_vld (iv),
            .in_s   (is_v),
            .in_c   (ic_v),
            .out_vld(ov),
            .out_s  (os),
            .out_c  (oc),
            .spill  (lvl_spill[l])
        );
    end

    assign out_vld   = g_lvl[D-1].ov;
    assign out_s     = g_lvl[D-1].os;
    assign out_c     = g_lvl[D-1].oc;
    assign spill_any = |lvl_spill;

endmodule

// File: rtl/mod_sum_tree_chk.sv
module mod_sum_tree_chk #(
    parameter int N   = 5,
    parameter int MOD = 11,
    localparam int W  = $clog2(MOD),
    localparam int D  = $clog2(N)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_vld,
    input logic [N*W-1:0] in_data,
    input logic           out_vld,
    input logic [W-1:0]   out_s,
    input logic [W-1:0]   out_c,
    input logic           spill_any
);

    logic [D-1:0] vsh;
    int unsigned  ssh [D];
    int unsigned  cur;

    always_comb begin
        cur = 0;
        for (int k = 0; k < N; k++) begin
            cur = cur + int'(in_data[k*W +: W]);
        end
        cur = cur % MOD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vsh <= '0;
            for (int i = 0; i < D; i++) ssh[i] <= 0;
        end else begin
            vsh[0] <= in_vld;
            ssh[0] <= cur;
            for (int i = 1; i < D; i++) begin
                vsh[i] <= vsh[i-1];
                ssh[i] <= ssh[i-1];
            end
        end
    end

    // R2
    lat_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == vsh[D-1]);

    // R1
    sum_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ((int'(out_s) + int'(out_c)) % MOD) == ssh[D-1]);

    // R1
    no_spill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spill_any);

    // R5
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !out_vld);

endmodule

bind mod_sum_tree mod_sum_tree_chk #(.N(N), .MOD(MOD)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .in_data  (in_data),
    .out_vld  (out_vld),
    .out_s    (out_s),
    .out_c    (out_c),
    .spill_any(spill_any)
);

// File: tb/sim_mod_sum_tree.sv
`timescale 1ns/1ps
module sim_mod_sum_tree;

    localparam int N0 = 5, M0 = 11, W0 = 4, D0 = 3;
    localparam int N1 = 7, M1 = 8,  W1 = 3, D1 = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              v0 = 1'b0, v1 = 1'b0;
    logic [N0*W0-1:0]  d0 = '0;
    logic [N1*W1-1:0]  d1 = '0;
    logic              ov0, ov1;
    logic [W0-1:0]     os0, oc0;
    logic [W1-1:0]     os1, oc1;

    mod_sum_tree #(.N(N0), .MOD(M0)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(v0), .in_data(d0),
        .out_vld(ov0), .out_s(os0), .out_c(oc0));

    mod_sum_tree #(.N(N1), .MOD(M1)) u1 (
        .clk(clk), .rst_n(rst_n), .in_vld(v1), .in_data(d1),
        .out_vld(ov1), .out_s(os1), .out_c(oc1));

    int    checks = 0, fails = 0, t = 0;
    bit    done = 0;
    bit    hv0 [16], hv1 [16];
    int    hs0 [16], hs1 [16];
    string hr0 [16], hr1 [16];
    int    a0 [N0];
    int    a1 [N1];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Compare the outputs with the entry driven D cycles earlier, then drive.
    task automatic step(input bit vin, input string tg0, input string tg1);
        int ix0, ix1, sum0, sum1, got;
        @(negedge clk);
        ix0 = (t - D0 + 16) % 16;
        ix1 = (t - D1 + 16) % 16;
        chk(ov0 == hv0[ix0], hv0[ix0] ? "R2" : "R3", int'(ov0), int'(hv0[ix0]));
        if (hv0[ix0]) begin
            got = (int'(os0) + int'(oc0)) % M0;
            chk(got == hs0[ix0], hr0[ix0], got, hs0[ix0]);
        end
        chk(ov1 == hv1[ix1], hv1[ix1] ? "R2" : "R3", int'(ov1), int'(hv1[ix1]));
        if (hv1[ix1]) begin
            got = (int'(os1) + int'(oc1)) % M1;
            chk(got == hs1[ix1], hr1[ix1], got, hs1[ix1]);
        end
        sum0 = 0;
        sum1 = 0;
        for (int k = 0; k < N0; k++) begin
            d0[k*W0 +: W0] = a0[k][W0-1:0];
            sum0 += a0[k];
        end
        for (int k = 0; k < N1; k++) begin
            d1[k*W1 +: W1] = a1[k][W1-1:0];
            sum1 += a1[k];
        end
        v0 = vin;
        v1 = vin;
        hv0[t % 16] = vin; hs0[t % 16] = sum0 % M0; hr0[t % 16] = tg0;
        hv1[t % 16] = vin; hs1[t % 16] = sum1 % M1; hr1[t % 16] = tg1;
        t++;
    endtask

    task automatic fill(input int val0, input int val1);
        for (int k = 0; k < N0; k++) a0[k] = val0;
        for (int k = 0; k < N1; k++) a1[k] = val1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog expired, actual running expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            hv0[i] = 0; hv1[i] = 0; hs0[i] = 0; hs1[i] = 0;
            hr0[i] = "R1"; hr1[i] = "R1";
        end
        fill(0, 0);
        repeat (3) @(negedge clk);
        // R5: quiet during reset
        chk(ov0 == 1'b0, "R5", int'(ov0), 0);
        chk(ov1 == 1'b0, "R5", int'(ov1), 0);
        rst_n = 1'b1;

        // all zeros
        fill(0, 0);
        step(1, "R1", "R7");
        // R4: every lane at M-1
        fill(M0 - 1, M1 - 1);
        step(1, "R4", "R7");
        step(1, "R4", "R7");
        // R6: only the unpaired last lane set
        fill(0, 0);
        a0[N0-1] = M0 - 1;
        a1[N1-1] = M1 - 1;
        step(1, "R6", "R6");
        a0[N0-1] = 1;
        a1[N1-1] = 3;
        step(1, "R6", "R6");
        // single non-zero lane at each position
        for (int p = 0; p < N1; p++) begin
            fill(0, 0);
            if (p < N0) a0[p] = M0 - 1 - p;
            a1[p] = M1 - 1;
            step(1, "R1", "R7");
        end
        // exhaustive sweep of the first two lanes, random elsewhere
        for (int x = 0; x < M0; x++) begin
            for (int y = 0; y < M0; y++) begin
                for (int k = 0; k < N0; k++) a0[k] = $urandom % M0;
                for (int k = 0; k < N1; k++) a1[k] = $urandom % M1;
                a0[0] = x;
                a0[1] = y;
                a1[0] = x % M1;
                a1[1] = y % M1;
                step(1, "R1", "R7");
            end
        end
        // random sets with periodic bubbles (R3)
        for (int n = 0; n < 3000; n++) begin
            for (int k = 0; k < N0; k++) a0[k] = $urandom % M0;
            for (int k = 0; k < N1; k++) a1[k] = $urandom % M1;
            if ((n % 5) == 3) begin
                step(0, "R3", "R3");
            end else begin
                step(1, "R1", "R7");
            end
        end
        // flush the pipeline
        fill(0, 0);
        for (int n = 0; n < D0 + 2; n++) step(0, "R3", "R3");
        finish_run();
    end

endmodule